// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits on the transmit path in front of the MAC. For each outgoing frame it first takes a short control record on a 32-bit sideband stream, then takes the frame one byte per beat. The record may ask for a 16-bit ones-complement checksum. The sum runs from a chosen start byte to the end of the frame, is seeded with a 16-bit value, and is written back at a chosen byte position in the frame.

The write position may lie anywhere in the frame, including before the summed region. For that reason the whole frame is held in an internal buffer of `DEPTH` bytes and is only forwarded once its last byte has arrived. Two configuration levels are checked once per frame, after it has been buffered. One is a transmit enable. The other is a pair of size-extension enables, which gate frames between the standard and the tagged maximum size. Each frame that is forwarded produces a one-cycle completion pulse.

The configuration inputs must stay stable from the first byte of a frame until that frame has been forwarded or dropped. Frames may be at most `DEPTH` bytes long.

Top module: `tx_csum_inserter`

## Requirements
- R1: After reset, `ctl_ready` is 1, and `in_ready`, `out_valid`, `ctl_err` and `tx_done` are 0.
- R2: A control record is the run of accepted control beats ending with `ctl_last`. Exactly 5 beats make a valid record, and the block then accepts frame bytes. Any other count pulses `ctl_err` in the cycle after the last beat and discards the record. The block then keeps waiting for a new record, with `in_ready` low.
- R3: When bit 0 of record word 0 is 0, the frame is forwarded byte for byte unchanged.
- R4: The checksum has three steps. First, the bytes from the start offset (word 1 bits [31:16]) to the end of the frame are summed as big-endian 16-bit words, and a trailing odd byte is taken as a high byte with a zero low byte. Second, the seed (word 2 bits [15:0]) is added. Third, carries are folded back into 16 bits with end-around carry and the result is complemented.
- R5: With offload on, the checksum's high byte replaces the byte at the write offset (word 1 bits [15:0]) and its low byte replaces the next byte. All other bytes pass unchanged.
- R6: When the write offset + 1 is not below the frame length, no byte is replaced.
- R7: When `cfg_tx_en` is 0, the frame is accepted and dropped: nothing appears on the output and `tx_done` stays 0.
- R8: When `cfg_jumbo_en` and `cfg_vlan_en` are both 0, frames of 1519 to 1522 bytes are dropped. 1518- and 1523-byte frames are forwarded, and setting either enable forwards the 1519 to 1522 range.
- R9: `tx_done` pulses for exactly one cycle, in the cycle after the last byte of a forwarded frame is accepted on the output.
- R10: While a frame is being forwarded, `in_ready` and `ctl_ready` are 0. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold.
- R11: When the start offset is at or beyond the end of the frame, the checksum is the folded, complemented seed alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit enable; 0 drops frames |
| cfg_jumbo_en | input | 1 | Oversize frames allowed |
| cfg_vlan_en | input | 1 | Tagged-size frames allowed |
| ctl_valid | input | 1 | Control beat valid |
| ctl_ready | output | 1 | Control beat accepted |
| ctl_data | input | 32 | Control word |
| ctl_last | input | 1 | Last word of the control record |
| ctl_err | output | 1 | Pulse: record length was not 5 words |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte, with the checksum patched in |
| out_last | output | 1 | Last byte of the output frame |
| tx_done | output | 1 | Pulse: a frame has been forwarded |

## Verification
The bench sweeps every start offset, including offsets past the end, for frame lengths 1 to 24. The write offsets it uses include positions before the start, the last byte, and past the end. It also uses all-ones data, so carry folding and odd-length padding are both exercised. A wrong byte order, a missing pad or a single fold would corrupt the patched bytes. A misplaced length compare would either patch a frame whose write offset runs off its end, or leave the final valid pair unpatched. The size gate is probed on each side of both bounds, so an off-by-one would forward or drop the wrong frame. Control records of four and six words check that a bad record is flagged and that the block recovers from it.

// File: rtl/tcsum_pkg.sv
package tcsum_pkg;

  localparam int STD_MAX_LEN = 1518;
  localparam int TAG_MAX_LEN = 1522;

  typedef enum logic [1:0] {
    ST_CTL  = 2'd0,
    ST_DATA = 2'd1,
    ST_FIN  = 2'd2,
    ST_SEND = 2'd3
  } tcsum_state_e;

  typedef struct packed {
    logic        ofl_en;
    logic [15:0] start_off;
    logic [15:0] put_off;
    logic [15:0] seed;
  } tcsum_rec_t;

  // end-around-carry fold of a 32-bit partial sum, then complement
  function automatic logic [15:0] fold_cpl(input logic [31:0] s);
    logic [16:0] f1;
    logic [16:0] f2;
    f1 = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    f2 = {1'b0, f1[15:0]} + {16'd0, f1[16]};
    return ~f2[15:0];
  endfunction

endpackage

// File: rtl/tcsum_ctl_rx.sv
module tcsum_ctl_rx
  import tcsum_pkg::*;
#(
  parameter int WORDS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        valid,
  input  logic [31:0] data,
  input  logic        last,
  output logic        rec_ok,
  output logic        rec_bad,
  output tcsum_rec_t  rec
);

  localparam int CW = $clog2(WORDS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  tcsum_rec_t    rec_q, rec_d;
  logic          hs;

  always_comb begin
    hs    = accept && valid;
    cnt_d = cnt_q;
    rec_d = rec_q;
    if (hs) begin
      if (last) begin
        cnt_d = '0;
      end else if (cnt_q != CW'(WORDS)) begin
        cnt_d = cnt_q + 1'b1;
      end
      if (cnt_q == CW'(0)) begin
        rec_d.ofl_en = data[0];
      end else if (cnt_q == CW'(1)) begin
        rec_d.start_off = data[31:16];
        rec_d.put_off   = data[15:0];
      end else if (cnt_q == CW'(2)) begin
        rec_d.seed = data[15:0];
      end
    end
    rec_ok  = hs && last && (cnt_q == CW'(WORDS - 1));
    rec_bad = hs && last && (cnt_q != CW'(WORDS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rec_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rec_q <= rec_d;
    end
  end

  assign rec = rec_q;

endmodule

// File: rtl/tcsum_accum.sv
module tcsum_accum #(
  parameter int AW   = 11,
  parameter int ACCW = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [AW-1:0]   idx,
  input  logic [15:0]     start,
  input  logic [7:0]      byte_in,
  output logic [ACCW-1:0] acc
);

  logic [ACCW-1:0] acc_q, acc_d;
  logic            in_rgn;
  logic            hi_half;
  logic [15:0]     term;

  always_comb begin
    in_rgn  = 32'(idx) >= 32'(start);
    hi_half = (idx[0] == start[0]);
    term    = hi_half ? {byte_in, 8'h00} : {8'h00, byte_in};
    acc_d   = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (en && in_rgn) begin
      acc_d = acc_q + ACCW'(term);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

endmodule

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter
  import tcsum_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int CTL_WORDS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_tx_en,
  input  logic        cfg_jumbo_en,
  input  logic        cfg_vlan_en,
  input  logic        ctl_valid,
  output logic        ctl_ready,
  input  logic [31:0] ctl_data,
  input  logic        ctl_last,
  output logic        ctl_err,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        tx_done
);

  localparam int AW   = $clog2(DEPTH);
  localparam int LW   = $clog2(DEPTH + 1);
  localparam int ACCW = AW + 17;

  tcsum_state_e    state_q, state_d;
  logic [AW-1:0]   wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]   rd_ptr_q, rd_ptr_d;
  logic [LW-1:0]   len_q, len_d;
  logic [15:0]     csum_q, csum_d;
  logic            patch_q, patch_d;
  logic            err_q, done_q, done_d;
  logic [7:0]      mem [DEPTH];

  tcsum_rec_t      rec;
  logic            rec_ok, rec_bad;
  logic [ACCW-1:0] acc;
  logic            in_hs, out_hs;
  logic            drop;
  logic [31:0]     len32;
  logic [7:0]      raw_byte;
  logic [16:0]     put17, rd17;

  assign ctl_ready = (state_q == ST_CTL);
  assign in_ready  = (state_q == ST_DATA);
  assign out_valid = (state_q == ST_SEND);
  assign in_hs     = in_valid && in_ready;
  assign out_hs    = out_valid && out_ready;

  tcsum_ctl_rx #(.WORDS(CTL_WORDS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .accept(ctl_ready), .valid(ctl_valid),
    .data(ctl_data), .last(ctl_last), .rec_ok(rec_ok), .rec_bad(rec_bad),
    .rec(rec)
  );

  tcsum_accum #(.AW(AW), .ACCW(ACCW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(rec_ok), .en(in_hs), .idx(wr_ptr_q),
    .start(rec.start_off), .byte_in(in_data), .acc(acc)
  );

  // frame store: plain array, no reset
  always_ff @(posedge clk) begin
    if (in_hs) mem[wr_ptr_q] <= in_data;
  end

  // output byte with checksum substitution
  always_comb begin
    raw_byte = mem[rd_ptr_q];
    put17    = {1'b0, rec.put_off};
    rd17     = 17'(rd_ptr_q);
    out_last = (LW'(rd_ptr_q) + 1'b1 == len_q);
    out_data = raw_byte;
    if (patch_q && rd17 == put17)          out_data = csum_q[15:8];
    if (patch_q && rd17 == put17 + 17'd1)  out_data = csum_q[7:0];
  end

  // next state
  always_comb begin
    state_d  = state_q;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    len_d    = len_q;
    csum_d   = csum_q;
    patch_d  = patch_q;
    done_d   = 1'b0;
    len32    = 32'(len_q);
    drop     = !cfg_tx_en ||
               (!cfg_jumbo_en && !cfg_vlan_en &&
                len32 > STD_MAX_LEN && len32 <= TAG_MAX_LEN);
    unique case (state_q)
      ST_CTL: begin
        if (rec_ok) begin
          state_d  = ST_DATA;
          wr_ptr_d = '0;
        end
      end
      ST_DATA: begin
        if (in_hs) begin
          wr_ptr_d = wr_ptr_q + 1'b1;
          if (in_last) begin
            len_d   = LW'(wr_ptr_q) + 1'b1;
            state_d = ST_FIN;
          end
        end
      end
      ST_FIN: begin
        csum_d   = fold_cpl(32'(acc) + 32'(rec.seed));
        patch_d  = rec.ofl_en && (({1'b0, rec.put_off} + 17'd1) < 17'(len_q));
        rd_ptr_d = '0;
        state_d  = drop ? ST_CTL : ST_SEND;
      end
      ST_SEND: begin
        if (out_hs) begin
          rd_ptr_d = rd_ptr_q + 1'b1;
          if (out_last) begin
            state_d = ST_CTL;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_CTL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_CTL;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      len_q    <= '0;
      csum_q   <= '0;
      patch_q  <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      len_q    <= len_d;
      csum_q   <= csum_d;
      patch_q  <= patch_d;
      err_q    <= rec_bad;
      done_q   <= done_d;
    end
  end

  assign ctl_err = err_q;
  assign tx_done = done_q;

endmodule

// File: rtl/tcsum_chk.sv
module tcsum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_tx_en,
  input logic        cfg_jumbo_en,
  input logic        cfg_vlan_en,
  input logic        ctl_valid,
  input logic        ctl_ready,
  input logic [31:0] ctl_data,
  input logic        ctl_last,
  input logic        ctl_err,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_data,
  input logic        in_last,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic        tx_done
);

  assert_busy_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!in_ready && !ctl_ready));

  assert_hold_while_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_done_follows_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(out_valid && out_ready && out_last));

  assert_last_gives_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> tx_done);

  assert_err_after_record_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_err |-> $past(ctl_valid && ctl_ready && ctl_last));

  assert_one_stream_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctl_ready, in_ready, out_valid}) <= 1);

endmodule

bind tx_csum_inserter tcsum_chk u_chk (.*);

// File: tb/tx_csum_inserter_tb.sv
module tx_csum_inserter_tb;

  localparam int DEPTH = 2048;

  logic clk;
  logic rst_n;
  logic cfg_tx_en, cfg_jumbo_en, cfg_vlan_en;
  logic ctl_valid, ctl_ready, ctl_last, ctl_err;
  logic [31:0] ctl_data;
  logic in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic out_valid, out_ready, out_last;
  logic [7:0] out_data;
  logic tx_done;

  int n_chk;
  int n_bad;
  bit finished;
  logic [7:0]  frm  [DEPTH];
  logic [7:0]  expb [DEPTH];
  logic [15:0] lfsr;

  tx_csum_inserter #(.DEPTH(DEPTH), .CTL_WORDS(5)) u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_ctl(input logic [31:0] w, input bit last);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_data = w; ctl_last = last;
    while (!ctl_ready) @(negedge clk);
    @(negedge clk);
    ctl_valid = 1'b0; ctl_last = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] d, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_rec(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input int nw);
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w;
      w = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : 32'h0;
      push_ctl(w, i == nw - 1);
    end
  endtask

  function automatic logic [15:0] model_csum(input int len, input int st, input logic [15:0] seed);
    longint s;
    s = seed;
    for (int i = st; i < len; i += 2) begin
      s += {frm[i], (i + 1 < len) ? frm[i + 1] : 8'h00};
    end
    while (s > 64'hFFFF) s = (s & 64'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic fill(input int len, input int k);
    for (int i = 0; i < len; i++)
      frm[i] = (k % 4 == 0) ? 8'hFF : 8'((i * 37 + k * 11) & 255);
  endtask

  task automatic run_frame(input int len, input bit ofl, input int st, input int put,
                           input logic [15:0] seed, input bit fwd, input string tag);
    logic [15:0] cs;
    int idx, tmo, bad_at;
    bit lst_ok, stall_ok;
    logic [7:0] bad_act;
    send_rec({31'd0, ofl}, {16'(st), 16'(put)}, {16'd0, seed}, 5);
    check(ctl_err == 1'b0 && in_ready == 1'b1, {tag, " R2 record accepted"}, {ctl_err, in_ready}, 2'b01);
    for (int i = 0; i < len; i++) push_byte(frm[i], i == len - 1);
    for (int i = 0; i < len; i++) expb[i] = frm[i];
    if (ofl && put + 1 < len) begin
      cs = model_csum(len, st, seed);
      expb[put] = cs[15:8];
      expb[put + 1] = cs[7:0];
    end
    if (!fwd) begin
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (out_valid || tx_done) quiet = 1'b0;
      end
      check(quiet && ctl_ready, {tag, " dropped frame stays off output"}, {out_valid, tx_done, ctl_ready}, 3'b001);
      return;
    end
    idx = 0; tmo = 0; bad_at = -1; bad_act = 8'h00; lst_ok = 1'b1; stall_ok = 1'b1;
    while (idx < len && tmo < 20000) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (lfsr[1:0] != 2'b00);
      tmo++;
      if (out_valid && !out_ready && (in_ready || ctl_ready)) stall_ok = 1'b0;
      if (out_valid && out_ready) begin
        if (out_data !== expb[idx] && bad_at < 0) begin
          bad_at = idx; bad_act = out_data;
        end
        if (out_last !== (idx == len - 1)) lst_ok = 1'b0;
        idx++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(bad_at < 0 && idx == len, {tag, " frame bytes"},
          (bad_at < 0) ? longint'(idx) : longint'(bad_act),
          (bad_at < 0) ? longint'(len) : longint'(expb[bad_at]));
    check(lst_ok, {tag, " out_last placement"}, lst_ok, 1);
    check(stall_ok, "R10 inputs closed while sending", stall_ok, 1);
    check(tx_done == 1'b1 && ctl_ready == 1'b1, "R9 tx_done after last byte", {tx_done, ctl_ready}, 2'b11);
    @(negedge clk);
    check(tx_done == 1'b0, "R9 tx_done single cycle", tx_done, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0; lfsr = 16'hACE1;
    rst_n = 1'b0;
    cfg_tx_en = 1'b1; cfg_jumbo_en = 1'b0; cfg_vlan_en = 1'b0;
    ctl_valid = 1'b0; ctl_data = '0; ctl_last = 1'b0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctl_ready && !in_ready && !out_valid && !ctl_err && !tx_done, "R1 reset state",
          {ctl_ready, in_ready, out_valid, ctl_err, tx_done}, 5'b10000);

    // R2 short and long records
    send_rec(32'h1, 32'h0, 32'h0, 4);
    check(ctl_err == 1'b1 && in_ready == 1'b0, "R2 four-word record flagged", {ctl_err, in_ready}, 2'b10);
    @(negedge clk);
    check(ctl_err == 1'b0, "R2 error is a pulse", ctl_err, 0);
    send_rec(32'h1, 32'h0, 32'h0, 6);
    check(ctl_err == 1'b1 && in_ready == 1'b0, "R2 six-word record flagged", {ctl_err, in_ready}, 2'b10);

    // R3 offload off leaves frame untouched
    for (int k = 0; k < 3; k++) begin
      fill(60 + k, k + 1);
      run_frame(60 + k, 1'b0, 14, 20 + k, 16'h1234, 1'b1, "R3");
    end

    // R4 R5 R6 R11 sweep of offsets
    for (int len = 1; len <= 24; len++) begin
      for (int st = 0; st <= len + 1; st++) begin
        int put;
        logic [15:0] seed;
        put  = (len * 7 + st * 3) % (len + 2);
        seed = 16'((len * 4099 + st * 613) ^ 16'hF00F);
        fill(len, len + st);
        if (st >= len)          run_frame(len, 1'b1, st, put, seed, 1'b1, "R11");
        else if (put + 1 >= len) run_frame(len, 1'b1, st, put, seed, 1'b1, "R6");
        else                     run_frame(len, 1'b1, st, put, seed, 1'b1, "R4 R5");
      end
    end
    fill(20, 8);
    run_frame(20, 1'b1, 0, 18, 16'hFFFF, 1'b1, "R5 last pair");
    run_frame(20, 1'b1, 0, 19, 16'hFFFF, 1'b1, "R6 last byte");

    // R7 transmit disabled
    cfg_tx_en = 1'b0;
    fill(64, 3);
    run_frame(64, 1'b1, 14, 16, 16'h0, 1'b0, "R7");
    cfg_tx_en = 1'b1;
    run_frame(64, 1'b1, 14, 16, 16'h0, 1'b1, "R7 re-enabled");

    // R8 size gate
    for (int len = 1517; len <= 1524; len++) begin
      fill(len, len);
      run_frame(len, 1'b1, 14, 30, 16'h00FF, (len < 1519 || len > 1522), "R8");
    end
    cfg_vlan_en = 1'b1;
    fill(1520, 5);
    run_frame(1520, 1'b1, 14, 30, 16'h0, 1'b1, "R8 tagged enable");
    cfg_vlan_en = 1'b0; cfg_jumbo_en = 1'b1;
    fill(1521, 6);
    run_frame(1521, 1'b1, 14, 30, 16'h0, 1'b1, "R8 oversize enable");
    cfg_jumbo_en = 1'b0;

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule